// File: doc/BRIEF.md
# Multi-Format Serial Audio Transmitter

This block turns a stereo pair of 24-bit two's-complement samples into one serial data line for a downstream audio processor. It runs in one of two roles. As clock source, it builds a bit clock, a left/right clock and a frame-sync strobe from a clock enable that ticks at 256 times the sample rate. As clock follower, it takes those three signals as inputs, brings them into its own clock domain, and shifts a word out only while the frame sync is high.

A 2-bit code selects one of four word placements. Three are 24 bits wide: start of the half-frame, one bit late, and end-aligned. The fourth is end-aligned and carries the 20 most significant bits. Parallel samples arrive on a valid strobe. The block holds the newest pair and moves it into the shifter at a frame boundary, so a sample written mid-frame never corrupts a word already going out.

Top module: `pcm_serial_tx`

## Requirements
- R1: In source role the first data bit of each word sits at this half-frame slot, counting from the left/right clock edge as slot 0: code 00 slot 0, code 01 slot 1, code 10 slot 8, code 11 slot 12.
- R2: Words go out MSB first. Codes 00, 01 and 10 send all 24 bits. Code 11 sends sample bits 23 down to 4.
- R3: The left sample goes out in the first half of each frame and the right sample in the second. The left half has the left/right clock high for codes 00, 10 and 11, and low for code 01.
- R4: In source role one bit-clock period lasts 4 clock-enable ticks (2 low, 2 high), and each half-frame holds exactly 32 bit clocks.
- R5: In source role the frame sync is high on exactly the bit clocks that carry data, 24 or 20 of them per half-frame. The data line is 0 whenever the frame sync is low.
- R6: In source role the data line and the left/right clock change only on a falling bit-clock edge.
- R7: The sample pair is captured at each frame start (source role) or at the start of each left word (follower role). A pair written during a frame goes out in the next frame, and the word in flight is unchanged.
- R8: In follower role the three clock outputs stay 0. The MSB is driven on the first falling bit-clock edge after a rising edge that sees the frame sync high after low. Each later falling edge with the frame sync high drives the next bit until the word is complete, and otherwise the line is 0. The channel is taken from the left/right clock level at the start, using the polarity of R3.
- R9: In follower role both 64- and 48-bit-clock frames are accepted, with any frame-sync delay after the left/right edge that leaves at least one low bit clock before the next word.
- R10: A synchronous active-high reset drives the data line and all clock outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Clock enable at 256 times the sample rate (source role) |
| slave_mode | input | 1 | 1: follow external clocks, 0: generate clocks |
| fmt_sel | input | 2 | Word placement code |
| smp_valid | input | 1 | Strobe for a new sample pair |
| smp_left | input | 24 | Left sample, two's complement |
| smp_right | input | 24 | Right sample, two's complement |
| bck_in | input | 1 | External bit clock (follower role) |
| lrck_in | input | 1 | External left/right clock (follower role) |
| fsync_in | input | 1 | External frame sync (follower role) |
| bck_out | output | 1 | Generated bit clock |
| lrck_out | output | 1 | Generated left/right clock |
| fsync_out | output | 1 | Generated frame sync |
| sdata | output | 1 | Serial data |

## Verification
The hardest case to reach is a new sample pair arriving while a word is half shifted, because the pair must then stay held until the next frame boundary. The stimulus reaches it by writing a fresh pair a fixed number of cycles after every left-word start, partway through that word, and expecting each pair one frame later. In follower role the bench varies the frame-sync delay at random on every half-frame, in both 64- and 48-bit frames, so the word start is set by the sync edge and never by the frame position.

// File: rtl/aud_tx_pkg.sv
package aud_tx_pkg;
  typedef enum logic [1:0] {
    FMT_LJ   = 2'b00,
    FMT_I2S  = 2'b01,
    FMT_RJ24 = 2'b10,
    FMT_RJ20 = 2'b11
  } fmt_e;

  // level of the left/right clock during the left half
  function automatic logic left_is_high(fmt_e f);
    return f != FMT_I2S;
  endfunction

  function automatic int unsigned word_bits(fmt_e f, int unsigned full_w, int unsigned short_w);
    return (f == FMT_RJ20) ? short_w : full_w;
  endfunction

  // slot of the first data bit after the left/right edge
  function automatic int unsigned lead_slots(fmt_e f, int unsigned half_bits, int unsigned wl);
    case (f)
      FMT_LJ:  return 0;
      FMT_I2S: return 1;
      default: return half_bits - wl;
    endcase
  endfunction
endpackage

// File: rtl/aud_sample_hold.sv
module aud_sample_hold #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         valid,
  input  logic [W-1:0] in_l,
  input  logic [W-1:0] in_r,
  input  logic         latch,
  output logic [W-1:0] pend_l,
  output logic [W-1:0] act_l,
  output logic [W-1:0] act_r
);
  logic [W-1:0] pend_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_l <= '0;
      pend_r <= '0;
      act_l  <= '0;
      act_r  <= '0;
    end else begin
      if (valid) begin
        pend_l <= in_l;
        pend_r <= in_r;
      end
      if (latch) begin
        act_l <= pend_l;
        act_r <= pend_r;
      end
    end
  end
endmodule

// File: rtl/aud_master_seq.sv
module aud_master_seq
  import aud_tx_pkg::*;
#(
  parameter int W             = 24,
  parameter int SHORT_W       = 20,
  parameter int HALF_BITS     = 32,
  parameter int TICKS_PER_BIT = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         tick,
  input  fmt_e         fmt,
  input  logic [W-1:0] act_l,
  input  logic [W-1:0] act_r,
  output logic         latch_o,
  output logic         bck_o,
  output logic         lrck_o,
  output logic         fsync_o,
  output logic         sdata_o
);
  localparam int PH_W   = $clog2(TICKS_PER_BIT);
  localparam int BIT_W  = $clog2(2 * HALF_BITS);
  localparam int SLOT_W = BIT_W - 1;
  localparam int CNT_W  = SLOT_W + 1;
  localparam int IDX_W  = $clog2(W);

  logic [PH_W-1:0]   phase, np;
  logic [BIT_W-1:0]  bitn, nb;
  logic [SLOT_W-1:0] slot;
  logic              half, in_win, bit_v, lr_lvl;
  logic [CNT_W-1:0]  wl, fs, off;
  logic [IDX_W-1:0]  idx;
  logic [W-1:0]      word;

  always_comb begin
    np     = (phase == PH_W'(TICKS_PER_BIT - 1)) ? '0 : phase + 1'b1;
    nb     = (np == '0) ? bitn + 1'b1 : bitn;
    slot   = nb[SLOT_W-1:0];
    half   = nb[BIT_W-1];
    wl     = CNT_W'(word_bits(fmt, W, SHORT_W));
    fs     = CNT_W'(lead_slots(fmt, HALF_BITS, word_bits(fmt, W, SHORT_W)));
    in_win = ({1'b0, slot} >= fs) && ({1'b0, slot} < fs + wl);
    off    = {1'b0, slot} - fs;
    idx    = IDX_W'(W - 1) - off[IDX_W-1:0];
    word   = half ? act_r : act_l;
    bit_v  = in_win ? word[idx] : 1'b0;
    lr_lvl = left_is_high(fmt) ^ half;
  end

  // capture one quarter bit before the first bit of the frame
  assign latch_o = en & tick & (np == PH_W'(TICKS_PER_BIT - 1)) & (bitn == '1);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      phase   <= PH_W'(TICKS_PER_BIT - 2);
      bitn    <= '1;
      bck_o   <= 1'b0;
      lrck_o  <= 1'b0;
      fsync_o <= 1'b0;
      sdata_o <= 1'b0;
    end else if (tick) begin
      phase <= np;
      bitn  <= nb;
      bck_o <= (np >= PH_W'(TICKS_PER_BIT / 2));
      if (np == '0) begin
        lrck_o  <= lr_lvl;
        fsync_o <= in_win;
        sdata_o <= bit_v;
      end
    end
  end

  a_r6_data_on_fall: assert property (@(posedge clk) disable iff (rst)
    (en && $past(en) && (sdata_o != $past(sdata_o))) |-> ($past(bck_o) && !bck_o));
  a_r6_lrck_on_fall: assert property (@(posedge clk) disable iff (rst)
    (en && $past(en) && (lrck_o != $past(lrck_o))) |-> ($past(bck_o) && !bck_o));
  a_r4_bck_needs_tick: assert property (@(posedge clk) disable iff (rst)
    (en && $past(en) && (bck_o != $past(bck_o))) |-> $past(tick));
  a_r5_data_inside_sync: assert property (@(posedge clk) disable iff (rst)
    (en && sdata_o) |-> fsync_o);
endmodule

// File: rtl/aud_slave_seq.sv
module aud_slave_seq
  import aud_tx_pkg::*;
#(
  parameter int W       = 24,
  parameter int SHORT_W = 20
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  fmt_e         fmt,
  input  logic         bck_i,
  input  logic         lrck_i,
  input  logic         fsync_i,
  input  logic [W-1:0] pend_l,
  input  logic [W-1:0] act_l,
  input  logic [W-1:0] act_r,
  output logic         latch_o,
  output logic         sdata_o
);
  localparam int PTR_W = $clog2(W + 1);
  localparam int IDX_W = $clog2(W);

  logic [2:0]       b_q;
  logic [1:0]       l_q, f_q;
  logic             fs_r, fs_rp, lr_r, chan_r;
  logic [PTR_W-1:0] ptr, wl;
  logic             rise, fall, start, start_right;
  logic [IDX_W-1:0] idx;
  logic [W-1:0]     cur;

  always_comb begin
    rise        = b_q[1] & ~b_q[2];
    fall        = ~b_q[1] & b_q[2];
    wl          = PTR_W'(word_bits(fmt, W, SHORT_W));
    start       = fs_r & ~fs_rp;
    start_right = (lr_r != left_is_high(fmt));
    cur         = chan_r ? act_r : act_l;
    idx         = IDX_W'(W - 1) - IDX_W'(ptr);
  end

  assign latch_o = en & fall & start & ~start_right;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      b_q     <= '0;
      l_q     <= '0;
      f_q     <= '0;
      fs_r    <= 1'b0;
      fs_rp   <= 1'b0;
      lr_r    <= 1'b0;
      chan_r  <= 1'b0;
      ptr     <= '0;
      sdata_o <= 1'b0;
    end else begin
      b_q <= {b_q[1:0], bck_i};
      l_q <= {l_q[0], lrck_i};
      f_q <= {f_q[0], fsync_i};
      if (rise) begin
        fs_r  <= f_q[1];
        fs_rp <= fs_r;
        lr_r  <= l_q[1];
      end
      if (fall) begin
        if (start) begin
          chan_r  <= start_right;
          ptr     <= PTR_W'(1);
          sdata_o <= start_right ? act_r[W-1] : pend_l[W-1];
        end else if (fs_r && (ptr < wl)) begin
          sdata_o <= cur[idx];
          ptr     <= ptr + 1'b1;
        end else begin
          sdata_o <= 1'b0;
        end
      end
    end
  end

  a_r8_ptr_bound: assert property (@(posedge clk) disable iff (rst)
    en |-> (ptr <= wl));
  a_r8_data_on_fall: assert property (@(posedge clk) disable iff (rst)
    (en && $past(en) && (sdata_o != $past(sdata_o))) |-> $past(fall));
endmodule

// File: rtl/pcm_serial_tx.sv
module pcm_serial_tx
  import aud_tx_pkg::*;
#(
  parameter int W             = 24,
  parameter int SHORT_W       = 20,
  parameter int HALF_BITS     = 32,
  parameter int TICKS_PER_BIT = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         slave_mode,
  input  logic [1:0]   fmt_sel,
  input  logic         smp_valid,
  input  logic [W-1:0] smp_left,
  input  logic [W-1:0] smp_right,
  input  logic         bck_in,
  input  logic         lrck_in,
  input  logic         fsync_in,
  output logic         bck_out,
  output logic         lrck_out,
  output logic         fsync_out,
  output logic         sdata
);
  fmt_e         fmt;
  logic         m_latch, s_latch, latch;
  logic         m_sd, s_sd;
  logic [W-1:0] pend_l, act_l, act_r;

  assign fmt   = fmt_e'(fmt_sel);
  assign latch = slave_mode ? s_latch : m_latch;
  assign sdata = slave_mode ? s_sd : m_sd;

  aud_sample_hold #(.W(W)) u_hold (
    .clk(clk), .rst(rst), .valid(smp_valid), .in_l(smp_left), .in_r(smp_right),
    .latch(latch), .pend_l(pend_l), .act_l(act_l), .act_r(act_r)
  );

  aud_master_seq #(.W(W), .SHORT_W(SHORT_W), .HALF_BITS(HALF_BITS),
                   .TICKS_PER_BIT(TICKS_PER_BIT)) u_master (
    .clk(clk), .rst(rst), .en(!slave_mode), .tick(tick), .fmt(fmt),
    .act_l(act_l), .act_r(act_r), .latch_o(m_latch), .bck_o(bck_out),
    .lrck_o(lrck_out), .fsync_o(fsync_out), .sdata_o(m_sd)
  );

  aud_slave_seq #(.W(W), .SHORT_W(SHORT_W)) u_slave (
    .clk(clk), .rst(rst), .en(slave_mode), .fmt(fmt), .bck_i(bck_in),
    .lrck_i(lrck_in), .fsync_i(fsync_in), .pend_l(pend_l), .act_l(act_l),
    .act_r(act_r), .latch_o(s_latch), .sdata_o(s_sd)
  );

  a_r10_quiet_after_reset: assert property (@(posedge clk)
    $past(rst) |-> (!bck_out && !lrck_out && !fsync_out && !sdata));
endmodule

// File: tb/pcm_serial_tx_test.sv
module pcm_serial_tx_test;
  logic clk = 0;
  always #10 clk = ~clk;

  logic rst = 1, tick = 0, slave_mode = 0, smp_valid = 0;
  logic [1:0] fmt_sel = 0;
  logic [23:0] smp_left = 0, smp_right = 0;
  logic bck_d = 0, lrck_d = 0, fsync_d = 0;
  logic bck_out, lrck_out, fsync_out, sdata;

  pcm_serial_tx uut (
    .clk(clk), .rst(rst), .tick(tick), .slave_mode(slave_mode), .fmt_sel(fmt_sel),
    .smp_valid(smp_valid), .smp_left(smp_left), .smp_right(smp_right),
    .bck_in(bck_d), .lrck_in(lrck_d), .fsync_in(fsync_d),
    .bck_out(bck_out), .lrck_out(lrck_out), .fsync_out(fsync_out), .sdata(sdata)
  );

  int errors = 0, checks = 0, tick_div = 1;
  bit armed = 0, done = 0;
  logic [23:0] pend_l = 0, pend_r = 0, snap_l = 0, snap_r = 0;
  event left_ev;

  function automatic int exp_len(logic [1:0] f);   return (f == 2'b11) ? 20 : 24; endfunction
  function automatic logic left_hi(logic [1:0] f); return f != 2'b01; endfunction
  function automatic int exp_first(logic [1:0] f);
    case (f) 2'b00: return 0; 2'b01: return 1; 2'b10: return 8; default: return 12; endcase
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // clock enable
  initial forever begin
    for (int c = 0; c < tick_div; c++) begin
      @(posedge clk); #2 tick = (c == 0);
    end
  end

  // receiver state
  logic prv_b, prv_f, prv_l, prv_sd, lr_cyc;
  int slot, gap_cnt, nbits, first_slot;
  bit in_word, w_ok, w_left, half_ok;
  logic [23:0] acc;

  task automatic finish_word();
    int el; logic [23:0] ev;
    el = exp_len(fmt_sel);
    ev = (w_left ? snap_l : snap_r) >> (24 - el);
    chk(nbits == el, slave_mode ? "R9" : "R5", "word length", nbits, el);
    chk(acc == ev, slave_mode ? "R8 R7" : "R2 R3 R7", "word value", acc, ev);
    if (!slave_mode) chk(first_slot == exp_first(fmt_sel), "R1", "first data slot", first_slot, exp_first(fmt_sel));
  endtask

  always @(negedge clk) begin
    logic cb, cl, cf, csd, cap;
    cb = slave_mode ? bck_d : bck_out;
    cl = slave_mode ? lrck_d : lrck_out;
    cf = slave_mode ? fsync_d : fsync_out;
    csd = sdata;
    if (rst) begin
      in_word = 0; half_ok = 0; gap_cnt = 0; slot = 0;
      prv_b = 0; prv_f = 0; prv_l = 0; prv_sd = 0; lr_cyc = 0;
    end else begin
      gap_cnt++;
      if (cb && !prv_b) begin
        if (!slave_mode && armed) chk(gap_cnt == 4 * tick_div, "R4", "bit clock period", gap_cnt, 4 * tick_div);
        gap_cnt = 0;
        if (cl !== prv_l) begin
          if (!slave_mode && half_ok) chk(slot + 1 == 32, "R4", "bits per half", slot + 1, 32);
          half_ok = armed; slot = 0; prv_l = cl;
        end else slot++;
        cap = slave_mode ? prv_f : cf;
        if (cap) begin
          if (!in_word) begin
            in_word = 1; w_ok = armed; nbits = 0; acc = 0; first_slot = slot;
            w_left = (cl == left_hi(fmt_sel));
            if (w_left) begin snap_l = pend_l; snap_r = pend_r; ->left_ev; end
          end
          acc = {acc[22:0], csd}; nbits++;
        end else begin
          if (in_word) begin in_word = 0; if (w_ok) finish_word(); end
          if (armed) chk(csd == 0, slave_mode ? "R8" : "R5", "line idle outside word", csd, 0);
        end
        prv_f = cf;
      end
      if (!slave_mode && armed) begin
        if (csd !== prv_sd) chk(!cb && prv_b, "R6", "data moved off falling edge", cb, 0);
        if (cl !== lr_cyc) chk(!cb && prv_b, "R6", "lrck moved off falling edge", cb, 0);
      end
      prv_b = cb; prv_sd = csd; lr_cyc = cl;
    end
  end

  // sample writer: one new pair per frame, partway into the left word
  initial begin
    int nw = 0;
    logic [23:0] l, r;
    void'($urandom(32'd2024));
    forever begin
      @(left_ev);
      repeat (30) @(posedge clk);
      case (nw)
        0: begin l = 24'h800000; r = 24'h7FFFFF; end
        1: begin l = 24'hFFFFFF; r = 24'h000001; end
        2: begin l = 24'h000000; r = 24'hFFFFFF; end
        3: begin l = 24'hA5A5A5; r = 24'h5A5A5A; end
        default: begin l = 24'($urandom); r = 24'($urandom); end
      endcase
      nw++;
      #2 smp_valid = 1; smp_left = l; smp_right = r; pend_l = l; pend_r = r;
      @(posedge clk); #2 smp_valid = 0;
    end
  end

  task automatic do_reset(bit sm, logic [1:0] f, int div);
    armed = 0;
    @(posedge clk); #2 rst = 1; slave_mode = sm; fmt_sel = f; tick_div = div;
    bck_d = 0; lrck_d = 0; fsync_d = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(!bck_out && !lrck_out && !fsync_out && !sdata, "R10", "outputs in reset",
        {bck_out, lrck_out, fsync_out, sdata}, 0);
    @(posedge clk); #2 rst = 0;
  endtask

  task automatic run_master(logic [1:0] f, int div);
    do_reset(0, f, div);
    repeat (3) @(left_ev);
    armed = 1;
    repeat (5) @(left_ev);
    armed = 0;
  endtask

  task automatic run_slave(logic [1:0] f, int bits);
    int half, maxd, d;
    do_reset(1, f, 1);
    half = bits / 2;
    maxd = half - exp_len(f) - 1;
    @(posedge clk); #2;
    for (int fr = 0; fr < 8; fr++) begin
      if (fr == 3) armed = 1;
      for (int h = 0; h < 2; h++) begin
        d = (fr == 3) ? maxd : $urandom_range(maxd, 0);
        for (int s = 0; s < half; s++) begin
          bck_d = 0;
          lrck_d = (h == 0) ? left_hi(f) : !left_hi(f);
          fsync_d = (s >= d) && (s < d + exp_len(f));
          repeat (6) @(posedge clk); #2;
          bck_d = 1;
          repeat (6) @(posedge clk); #2;
        end
      end
    end
    armed = 0;
    @(negedge clk);
    chk(!bck_out && !lrck_out && !fsync_out, "R8", "clock outputs in follower role",
        {bck_out, lrck_out, fsync_out}, 0);
  endtask

  initial begin
    for (int f = 0; f < 4; f++) run_master(2'(f), 1);
    run_master(2'b01, 3);
    run_master(2'b11, 2);
    for (int f = 0; f < 4; f++) run_slave(2'(f), 64);
    run_slave(2'b11, 48);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R4 watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule